// File: doc/BRIEF.md
# Chunked SPI Data-Phase Engine

This block carries out the data phase of a block transfer over a byte-level SPI shifter, in either direction, once the command phase has been handled elsewhere. A start strobe loads the direction, a 16-bit byte count, a CRC-enable flag and a clockless flag. The engine then splits the transfer into chunks of at most `MAX_CHUNK` bytes and clocks every byte through a full-duplex request/acknowledge shifter port.

On a write, each chunk is framed by a header byte that marks its position in the transfer. Optional zero trailer bytes follow the chunk. After the last chunk the engine reads back a short acknowledge pattern and checks it.

On a read, the engine hunts for a header byte before each chunk and delivers the payload to a local sink stream. When a trailer is present it is discarded. Local streams apply backpressure by holding back the shifter request, so no byte is ever dropped. Each transfer ends with a one-cycle `done_o`, and `err_o` accompanies it when the transfer failed.

Top module: `spi_chunk_xfer`

## Requirements
- R1: A start with a byte count of zero gives `done_o` in the next cycle with `err_o` low and no shifter request at any time.
- R2: The transfer is split into chunks that each carry min(remaining, `MAX_CHUNK`) payload bytes until nothing remains. Every frame byte is clocked exactly once.
- R3: Every write chunk begins with header byte 8'hF0 OR order, where order sits in bits [1:0]. Order is 3 for the chunk that finishes the transfer (this includes a single-chunk transfer), 1 for the first chunk of a multi-chunk transfer, and 2 for any other chunk.
- R4: On a write with `crc_en_i`=1, two 8'h00 trailer bytes follow each chunk's payload. With `crc_en_i`=0 no trailer is sent.
- R5: After the last write chunk the engine reads 2 bytes (`crc_en_i`=1) or 3 bytes (`crc_en_i`=0). `err_o` is raised with `done_o` unless the last of these bytes is 8'h00 and the one before it is 8'hC3.
- R6: Before each read chunk the engine reads bytes until one has bits [7:4] = 4'hF. If `HUNT_TRIES` bytes in a row fail this test, it ends the transfer with `err_o`.
- R7: The read payload bytes that follow a header are passed to the sink in order. Two trailer bytes after each chunk are read and discarded when `crc_en_i`=1 and `clockless_i`=0; otherwise no trailer is read.
- R8: The shifter request during write payload is held back while `src_valid_i` is low, and during read payload while `snk_ready_i` is low. No byte is lost or duplicated.
- R9: `done_o` is a one-cycle pulse, `err_o` is high only together with `done_o`, and after reset the block is idle with no shifter request.
- R10: Every byte clocked out, other than write headers and write payload, is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| len_i | input | CNT_W | Total payload byte count |
| crc_en_i | input | 1 | Trailer bytes present |
| clockless_i | input | 1 | Read without trailer |
| done_o | output | 1 | Transfer finished (pulse) |
| err_o | output | 1 | Transfer failed, valid with done_o |
| busy_o | output | 1 | Transfer in progress |
| src_data_i | input | 8 | Write payload byte |
| src_valid_i | input | 1 | Write payload byte available |
| src_ready_o | output | 1 | Write payload byte taken |
| snk_data_o | output | 8 | Read payload byte |
| snk_valid_o | output | 1 | Read payload byte present |
| snk_ready_i | input | 1 | Sink can take a byte |
| sh_req_o | output | 1 | Shifter byte exchange request |
| sh_tx_o | output | 8 | Byte to shift out |
| sh_ack_i | input | 1 | Shifter exchange completes this cycle |
| sh_rx_i | input | 8 | Byte shifted in, valid with sh_ack_i |

## Verification
The bench sweeps every byte count from 0 to more than three chunks of a small `MAX_CHUNK`, in both directions and under every combination of the CRC and clockless flags. These sweeps separate single-chunk framing from first, middle and last framing, and they show whether trailers appear exactly when the flags ask for them. On reads, the trailer is filled with a byte whose upper nibble is F, so a trailer that is wrongly skipped or wrongly kept changes the delivered payload. Junk runs before headers are varied and pushed to exactly `HUNT_TRIES`-1 and `HUNT_TRIES`, which separates a late success from a give-up. Corrupting each of the two write acknowledge bytes in turn shows that both are checked. Source and sink stall in periodic patterns, which exposes lost or repeated bytes.

// File: rtl/spi_chunk_pkg.sv
`timescale 1ns/1ps
package spi_chunk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_W_HDR, ST_W_DATA, ST_W_CRC, ST_W_ACK,
    ST_R_HUNT, ST_R_DATA, ST_R_CRC, ST_FIN
  } xfer_st_e;

  localparam logic [3:0] HDR_NIB   = 4'hF;
  localparam logic [1:0] ORD_FIRST = 2'd1;
  localparam logic [1:0] ORD_MID   = 2'd2;
  localparam logic [1:0] ORD_LAST  = 2'd3;
  localparam logic [7:0] ACK_TOKEN = 8'hC3;
  localparam logic [7:0] ACK_TAIL  = 8'h00;
  localparam logic [7:0] FILL_BYTE = 8'h00;
endpackage

// File: rtl/spi_chunk_ctr.sv
`timescale 1ns/1ps
module spi_chunk_ctr #(
  parameter int CNT_W     = 16,
  parameter int MAX_CHUNK = 8192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             open_i,
  input  logic             take_i,
  output logic             rem_zero_o,
  output logic             last_byte_o,
  output logic             chunk_end_o,
  output logic [1:0]       order_o
);
  import spi_chunk_pkg::*;

  localparam int              CH_W  = $clog2(MAX_CHUNK + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CHUNK);

  logic [CNT_W-1:0] rem_q;
  logic [CH_W-1:0]  left_q;
  logic             first_q;
  logic             fits;
  logic [CH_W-1:0]  chunk_len;

  assign fits      = (rem_q <= MAX_C);
  assign chunk_len = fits ? CH_W'(rem_q) : CH_W'(MAX_CHUNK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      rem_q   <= total_i;
      left_q  <= '0;
      first_q <= 1'b1;
    end else begin
      if (open_i) begin
        left_q  <= chunk_len;
        first_q <= 1'b0;
      end
      if (take_i) begin
        rem_q  <= rem_q - 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign rem_zero_o  = (rem_q == '0);
  assign last_byte_o = (rem_q == CNT_W'(1));
  assign chunk_end_o = (left_q == CH_W'(1));
  assign order_o     = fits ? ORD_LAST : (first_q ? ORD_FIRST : ORD_MID);
endmodule

// File: rtl/spi_hunt_ctr.sv
`timescale 1ns/1ps
module spi_hunt_ctr #(
  parameter int TRIES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic miss_i,
  output logic give_up_o
);
  localparam int W = $clog2(TRIES + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (miss_i) cnt_q <= cnt_q + 1'b1;
  end

  // the miss that uses up the last try ends the hunt
  assign give_up_o = miss_i && (cnt_q == W'(TRIES - 1));
endmodule

// File: rtl/spi_ack_chk.sv
`timescale 1ns/1ps
module spi_ack_chk (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);
  import spi_chunk_pkg::*;

  logic [7:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (clr_i)  prev_q <= '0;
    else if (push_i) prev_q <= byte_i;
  end

  // evaluated on the final byte: previous must be the token, current the tail
  assign ok_o = (prev_q == ACK_TOKEN) && (byte_i == ACK_TAIL);
endmodule

// File: rtl/spi_chunk_xfer.sv
`timescale 1ns/1ps
module spi_chunk_xfer #(
  parameter int CNT_W      = 16,
  parameter int MAX_CHUNK  = 8192,
  parameter int HUNT_TRIES = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             crc_en_i,
  input  logic             clockless_i,
  output logic             done_o,
  output logic             err_o,
  output logic             busy_o,
  input  logic [7:0]       src_data_i,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic [7:0]       snk_data_o,
  output logic             snk_valid_o,
  input  logic             snk_ready_i,
  output logic             sh_req_o,
  output logic [7:0]       sh_tx_o,
  input  logic             sh_ack_i,
  input  logic [7:0]       sh_rx_i
);
  import spi_chunk_pkg::*;

  xfer_st_e   state_q, state_d;
  logic       crc_q, cl_q, err_q, err_d;
  logic [1:0] tail_q, tail_d;
  logic       go, ld, open_c, take, miss;
  logic       rem_zero, last_byte, chunk_end, give_up, ack_ok;
  logic [1:0] order;
  logic       rd_trailer;
  logic [1:0] ack_last;

  assign go         = sh_req_o & sh_ack_i;
  assign rd_trailer = crc_q & ~cl_q;
  assign ack_last   = crc_q ? 2'd1 : 2'd2;

  spi_chunk_ctr #(.CNT_W(CNT_W), .MAX_CHUNK(MAX_CHUNK)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .total_i    (len_i),
    .open_i     (open_c),
    .take_i     (take),
    .rem_zero_o (rem_zero),
    .last_byte_o(last_byte),
    .chunk_end_o(chunk_end),
    .order_o    (order)
  );

  spi_hunt_ctr #(.TRIES(HUNT_TRIES)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_R_HUNT),
    .miss_i   (miss),
    .give_up_o(give_up)
  );

  spi_ack_chk u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_W_ACK),
    .push_i(go && (state_q == ST_W_ACK)),
    .byte_i(sh_rx_i),
    .ok_o  (ack_ok)
  );

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    tail_d   = tail_q;
    sh_req_o = 1'b0;
    sh_tx_o  = FILL_BYTE;
    ld       = 1'b0;
    open_c   = 1'b0;
    take     = 1'b0;
    miss     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld     = 1'b1;
          err_d  = 1'b0;
          tail_d = '0;
          if (len_i == '0) state_d = ST_FIN;
          else             state_d = wr_i ? ST_W_HDR : ST_R_HUNT;
        end
      end
      ST_W_HDR: begin
        sh_req_o = 1'b1;
        sh_tx_o  = {HDR_NIB, 2'b00, order};
        if (go) begin
          open_c  = 1'b1;
          state_d = ST_W_DATA;
        end
      end
      ST_W_DATA: begin
        sh_req_o = src_valid_i;
        sh_tx_o  = src_data_i;
        if (go) begin
          take = 1'b1;
          if (chunk_end) begin
            tail_d = '0;
            if (crc_q)          state_d = ST_W_CRC;
            else if (last_byte) state_d = ST_W_ACK;
            else                state_d = ST_W_HDR;
          end
        end
      end
      ST_W_CRC: begin
        sh_req_o = 1'b1;
        if (go) begin
          tail_d = tail_q + 1'b1;
          if (tail_q == 2'd1) begin
            tail_d  = '0;
            state_d = rem_zero ? ST_W_ACK : ST_W_HDR;
          end
        end
      end
      ST_W_ACK: begin
        sh_req_o = 1'b1;
        if (go) begin
          tail_d = tail_q + 1'b1;
          if (tail_q == ack_last) begin
            err_d   = ~ack_ok;
            state_d = ST_FIN;
          end
        end
      end
      ST_R_HUNT: begin
        sh_req_o = 1'b1;
        if (go) begin
          if (sh_rx_i[7:4] == HDR_NIB) begin
            open_c  = 1'b1;
            state_d = ST_R_DATA;
          end else begin
            miss = 1'b1;
            if (give_up) begin
              err_d   = 1'b1;
              state_d = ST_FIN;
            end
          end
        end
      end
      ST_R_DATA: begin
        sh_req_o = snk_ready_i;
        if (go) begin
          take = 1'b1;
          if (chunk_end) begin
            tail_d = '0;
            if (rd_trailer)     state_d = ST_R_CRC;
            else if (last_byte) state_d = ST_FIN;
            else                state_d = ST_R_HUNT;
          end
        end
      end
      ST_R_CRC: begin
        sh_req_o = 1'b1;
        if (go) begin
          tail_d = tail_q + 1'b1;
          if (tail_q == 2'd1) begin
            tail_d  = '0;
            state_d = rem_zero ? ST_FIN : ST_R_HUNT;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      tail_q  <= '0;
      crc_q   <= 1'b0;
      cl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      tail_q  <= tail_d;
      if (state_q == ST_IDLE && start_i) begin
        crc_q <= crc_en_i;
        cl_q  <= clockless_i;
      end
    end
  end

  assign done_o      = (state_q == ST_FIN);
  assign err_o       = done_o & err_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign src_ready_o = go && (state_q == ST_W_DATA);
  assign snk_valid_o = go && (state_q == ST_R_DATA);
  assign snk_data_o  = sh_rx_i;
endmodule

// File: rtl/spi_chunk_xfer_chk.sv
`timescale 1ns/1ps
module spi_chunk_xfer_chk #(
  parameter int CNT_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [CNT_W-1:0]       len_i,
  input logic                   done_o,
  input logic                   err_o,
  input logic                   busy_o,
  input logic                   src_valid_i,
  input logic                   src_ready_o,
  input logic                   snk_valid_o,
  input logic                   snk_ready_i,
  input logic                   sh_req_o,
  input logic [7:0]             sh_tx_o,
  input logic                   sh_ack_i,
  input spi_chunk_pkg::xfer_st_e state_i
);
  import spi_chunk_pkg::*;

  p_zero_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && len_i == '0) |=> (done_o && !err_o));

  p_hdr_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_W_HDR && sh_req_o) |->
      (sh_tx_o[7:4] == 4'hF && sh_tx_o[3:2] == 2'b00 && sh_tx_o[1:0] != 2'b00));

  p_trailer_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_W_CRC && sh_req_o) |-> (sh_tx_o == 8'h00));

  p_src_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> (src_valid_i && sh_ack_i));

  p_snk_give_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o |-> snk_ready_i);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sh_req_o);

  p_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_req_o && state_i != ST_W_HDR && state_i != ST_W_DATA) |-> (sh_tx_o == 8'h00));
endmodule

bind spi_chunk_xfer spi_chunk_xfer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_i      (len_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .busy_o     (busy_o),
  .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o),
  .snk_valid_o(snk_valid_o),
  .snk_ready_i(snk_ready_i),
  .sh_req_o   (sh_req_o),
  .sh_tx_o    (sh_tx_o),
  .sh_ack_i   (sh_ack_i),
  .state_i    (state_q)
);

// File: tb/tb_spi_chunk_xfer.sv
`timescale 1ns/1ps
module tb_spi_chunk_xfer;
  localparam int MC = 4;
  localparam int HT = 5;
  localparam int AW = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, wr_i = 1'b0, crc_en_i = 1'b0, clockless_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        done_o, err_o, busy_o;
  logic [7:0]  src_data_i = '0;
  logic        src_valid_i = 1'b0, src_ready_o;
  logic [7:0]  snk_data_o;
  logic        snk_valid_o, snk_ready_i = 1'b0;
  logic        sh_req_o, sh_ack_i = 1'b0;
  logic [7:0]  sh_tx_o, sh_rx_i = '0;

  spi_chunk_xfer #(.CNT_W(16), .MAX_CHUNK(MC), .HUNT_TRIES(HT)) dut (.*);

  always #10 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  logic [7:0] rx_arr [AW];
  logic [7:0] exp_tx [AW];
  logic [7:0] tx_log [AW];
  logic [7:0] exp_snk[AW];
  logic [7:0] got_snk[AW];
  int idx = 0, src_idx = 0, got_n = 0, pend = 0, cyc = 0, seed = 0;

  function automatic logic [7:0] pat(int s, int i);
    return 8'(i * 37 + s * 11 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // shifter, source and sink model
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (sh_ack_i) begin
        sh_ack_i = 1'b0;
        if (pend != 0) begin src_idx++; pend = 0; end
      end else begin
        src_valid_i = (cyc % 3) != 2;
        src_data_i  = pat(seed, src_idx);
        snk_ready_i = (cyc % 4) != 3;
        #1;
        if (sh_req_o) begin
          if (idx < AW) begin
            tx_log[idx] = sh_tx_o;
            sh_rx_i     = rx_arr[idx];
          end else sh_rx_i = 8'h00;
          idx++;
          sh_ack_i = 1'b1;
          #1;
          if (src_ready_o) pend = 1;
          if (snk_valid_o && got_n < AW) begin
            got_snk[got_n] = snk_data_o;
            got_n++;
          end
        end
      end
    end
  end

  // mode: 0 normal, 1 hunt at limit, 2 hunt exhausted, 3 bad ack tail, 4 bad ack token
  task automatic run(bit wr, int n, bit crc, bit cl, int mode);
    int p, rem, c, s, k, j, cnt, mis;
    bit first, exp_err;
    p = 0; rem = n; c = 0; s = 0; first = 1'b1; exp_err = 1'b0;
    for (int i = 0; i < AW; i++) begin
      rx_arr[i] = 8'h00; exp_tx[i] = 8'h00; tx_log[i] = 8'hEE;
    end
    seed = n + (wr ? 100 : 0) + (crc ? 7 : 0);
    idx = 0; src_idx = 0; got_n = 0; pend = 0;
    if (wr) begin
      while (rem > 0) begin
        k = (rem < MC) ? rem : MC;
        exp_tx[p] = 8'hF0 | ((rem <= MC) ? 8'd3 : (first ? 8'd1 : 8'd2));
        p++;
        for (int b = 0; b < k; b++) begin exp_tx[p] = pat(seed, s); s++; p++; end
        if (crc) p += 2;
        rem -= k; first = 1'b0;
      end
      if (n > 0) begin
        if (!crc) begin rx_arr[p] = 8'h77; p++; end
        rx_arr[p] = (mode == 4) ? 8'hC2 : 8'hC3; p++;
        rx_arr[p] = (mode == 3) ? 8'h01 : 8'h00; p++;
        exp_err = (mode >= 3);
      end
    end else begin
      while (rem > 0) begin
        k = (rem < MC) ? rem : MC;
        j = (mode == 1 && c == 0) ? HT - 1 : (mode == 2 && c == 0) ? HT : (c + n) % 3;
        for (int q = 0; q < j; q++) begin rx_arr[p] = 8'h3C + 8'(q); p++; end
        if (mode == 2) begin exp_err = 1'b1; break; end
        rx_arr[p] = 8'hF0 | 8'(c % 16); p++;
        for (int b = 0; b < k; b++) begin
          rx_arr[p] = pat(seed, s); exp_snk[s] = pat(seed, s); s++; p++;
        end
        if (crc && !cl) begin rx_arr[p] = 8'hF5; rx_arr[p+1] = 8'h5A; p += 2; end
        rem -= k; c++;
      end
    end

    @(negedge clk_i);
    wr_i = wr; len_i = 16'(n); crc_en_i = crc; clockless_i = cl; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 3000) begin @(negedge clk_i); cnt++; end
    #4;
    chk(done_o == 1'b1, "R9 done reached", int'(done_o), 1);
    if (n == 0) chk(cnt == 1 && idx == 0, "R1 zero-length immediate", cnt * 1000 + idx, 1000);
    chk(err_o == exp_err, wr ? "R5 ack verdict" : "R6 hunt verdict", int'(err_o), int'(exp_err));
    chk(idx == p, "R2 frame length", idx, p);
    mis = 0;
    for (int i = 0; i < p && i < AW; i++) if (tx_log[i] != exp_tx[i]) mis++;
    chk(mis == 0, wr ? "R3 R4 write frame bytes" : "R10 read fill bytes", mis, 0);
    if (wr) chk(src_idx + pend == n, "R8 source bytes consumed", src_idx + pend, n);
    else if (!exp_err) begin
      mis = 0;
      for (int i = 0; i < n; i++) if (got_snk[i] != exp_snk[i]) mis++;
      chk(got_n == n && mis == 0, "R7 read payload", got_n * 1000 + mis, n * 1000);
    end else chk(got_n == 0, "R6 no payload after give-up", got_n, 0);
    @(negedge clk_i);
    #4;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done pulse", int'(done_o) + int'(busy_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #4;
    chk(!done_o && !busy_o && !sh_req_o && !err_o, "R9 reset state",
        int'(done_o) + int'(busy_o) + int'(sh_req_o) + int'(err_o), 0);
    for (int w = 0; w < 2; w++)
      for (int n = 0; n < 14; n++)
        for (int cr = 0; cr < 2; cr++)
          for (int cl = 0; cl < 2; cl++)
            run(w[0], n, cr[0], cl[0], 0);
    run(1'b0, 6, 1'b1, 1'b0, 1);   // R6 success on the last allowed try
    run(1'b0, 5, 1'b0, 1'b0, 1);
    run(1'b0, 5, 1'b1, 1'b0, 2);   // R6 give-up
    run(1'b0, 9, 1'b0, 1'b1, 2);
    run(1'b1, 5, 1'b1, 1'b0, 3);   // R5 bad tail byte
    run(1'b1, 5, 1'b0, 1'b0, 3);
    run(1'b1, 9, 1'b1, 1'b0, 4);   // R5 bad token byte
    run(1'b1, 3, 1'b0, 1'b0, 4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule